// File: doc/BRIEF.md
# Palette RAM Host Access Port

This block sits between a host register interface and a 256-entry color lookup RAM that a pixel pipeline reads on every dot clock. The host first writes a 9-bit index register. It then moves 24-bit color entries through a 32-bit data register. Each palette read or write of that data register steps the index by one, so a block transfer of consecutive entries needs only one index load.

The RAM has a single port. In any cycle where the host reads or writes a palette entry, the host owns that port for exactly that cycle. The pixel color output then repeats its previous value for one extra dot clock instead of showing a corrupted lookup, which keeps the picture free of glitches. A configuration input turns data-register reads into reads of a 24-bit pixel-stream signature supplied from outside. Those reads do not touch the RAM and do not move the index.

Everything runs in the dot-clock domain. Reset is synchronous and active high. It clears the index and the output registers. The palette contents stay undefined after reset.

Top module: `pal_host_port`

## Requirements
- R1: After reset, `pal_index` is 0, `rd_valid` is 0 and `pix_color` is 0.
- R2: A cycle with `idx_load` high sets `pal_index` to `idx_wdata` (all 9 bits, including bit 8) at the next clock edge.
- R3: A data write stores `data_wdata[23:0]` into palette entry `pal_index[7:0]`. Bits 31:24 go to a reserved byte register, and every data-register read returns that register's value in `rd_data[31:24]`.
- R4: Each palette data write and each palette data read increments `pal_index` by one, modulo 512. Entry selection uses only bits 7:0 of the index, so index 256 and index 0 reach the same entry.
- R5: A data read requested in cycle t gives `rd_valid` high for one cycle, with `rd_data` valid, after the second clock edge that follows t. Consecutive read requests return in order, one per cycle.
- R6: With no host use of the RAM, `pix_color` after the second clock edge following a cycle equals the palette entry at the `pix_index` value of that cycle.
- R7: If the host reads or writes the palette in cycle t, the `pix_color` value after the second edge following t equals the value after the first edge (the output is held for one extra dot clock).
- R8: While `sig_rd_en` is high, a data read returns `{reserved byte, sig_value}`, with `sig_value` sampled in the request cycle, on the same latency as R5. It leaves `pal_index` unchanged and does not hold the pixel output.
- R9: When `data_wr` and `data_rd` are both high in one cycle, only the write happens: one increment, and no `rd_valid` for that cycle. When `idx_load` coincides with a data access, the access uses the old index and the loaded value wins over the increment.
- R10: Data writes behave the same whether `sig_rd_en` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_load | input | 1 | Load the palette index register |
| idx_wdata | input | 9 | New index value |
| data_wr | input | 1 | Write the data register (one-cycle pulse per access) |
| data_rd | input | 1 | Read the data register (one-cycle pulse per access) |
| data_wdata | input | 32 | Write data: color in 23:0, reserved byte in 31:24 |
| sig_rd_en | input | 1 | Redirect data reads to the signature value |
| sig_value | input | 24 | Current pixel-stream signature |
| pix_index | input | 8 | Pixel pipeline lookup index |
| pal_index | output | 9 | Current palette index register |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 32 | Read return data |
| pix_color | output | 24 | Looked-up pixel color |

## Verification
Four properties are checked on every cycle:
- A load sets the index, and a palette access advances it by one.
- A signature read leaves the index alone.
- Read returns arrive exactly two cycles after their requests.
- The pixel output is frozen in the cycle that follows a host RAM slot.

The bench scenarios cover what these properties cannot see. They show that written colors come back through both the host read path and the pixel path, and that the reserved byte round-trips. They also cover index wrap at 511 and aliasing at 256, signature data contents, write-over-read priority, and index-load-over-increment priority.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

  localparam int unsigned PAL_IDX_W   = 9;
  localparam int unsigned PAL_ENTRY_W = 8;
  localparam int unsigned PAL_COLOR_W = 24;
  localparam int unsigned PAL_BUS_W   = 32;

  // Operation the host presents to the block in one dot-clock cycle.
  typedef enum logic [1:0] {
    HOP_IDLE     = 2'd0,
    HOP_WRITE    = 2'd1,
    HOP_PAL_READ = 2'd2,
    HOP_SIG_READ = 2'd3
  } host_op_e;

endpackage

// File: rtl/pal_index_reg.sv
`timescale 1ns/1ps
module pal_index_reg #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q;

  // A load takes priority over the increment; the increment wraps naturally.
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_val;
    end else if (advance) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign idx = idx_q;

  // R2: a load is visible on the next cycle
  a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
    load |=> idx == $past(load_val));

  // R4: an access without a load steps the index by one
  a_r4_index_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> idx == IDX_W'($past(idx) + IDX_W'(1)));

endmodule

// File: rtl/pal_ram.sv
`timescale 1ns/1ps
module pal_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // Single-port, read-first, registered read: block RAM template.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pal_pixel_hold.sv
`timescale 1ns/1ps
module pal_pixel_hold #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_slot,
  input  logic [DW-1:0] ram_q,
  output logic [DW-1:0] pix_color
);

  logic          slot_host_q;
  logic [DW-1:0] pix_q;

  // Remember who owned the RAM slot whose data is now on ram_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_host_q <= 1'b0;
    end else begin
      slot_host_q <= host_slot;
    end
  end

  // Only pixel-owned slots update the output; host slots repeat it.
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q <= '0;
    end else if (!slot_host_q) begin
      pix_q <= ram_q;
    end
  end

  assign pix_color = pix_q;

  // R7: a host slot two cycles back freezes the output for one more cycle
  a_r7_pixel_hold: assert property (@(posedge clk) disable iff (rst)
    $past(host_slot, 2) |-> pix_q == $past(pix_q));

endmodule

// File: rtl/pal_host_read.sv
`timescale 1ns/1ps
module pal_host_read #(
  parameter int unsigned DW    = 24,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_pal,
  input  logic             rd_sig,
  input  logic [DW-1:0]    sig_value,
  input  logic [DW-1:0]    ram_q,
  input  logic [BUS_W-DW-1:0] rsvd_byte,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_data
);

  logic          pend_pal_q;
  logic          pend_sig_q;
  logic [DW-1:0] sig_cap_q;
  logic          rvalid_q;
  logic [BUS_W-1:0] rdata_q;

  // Stage 1: align with the RAM read; capture the signature at request time.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pal_q <= 1'b0;
      pend_sig_q <= 1'b0;
      sig_cap_q  <= '0;
    end else begin
      pend_pal_q <= rd_pal;
      pend_sig_q <= rd_sig;
      if (rd_sig) begin
        sig_cap_q <= sig_value;
      end
    end
  end

  // Stage 2: registered return with the reserved byte on top.
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= pend_pal_q || pend_sig_q;
      if (pend_sig_q) begin
        rdata_q <= {rsvd_byte, sig_cap_q};
      end else if (pend_pal_q) begin
        rdata_q <= {rsvd_byte, ram_q};
      end
    end
  end

  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;

  // R5: every read request returns exactly two cycles later, and nothing else does
  a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
    rvalid_q == ($past(rd_pal, 2) || $past(rd_sig, 2)));

endmodule

// File: rtl/pal_host_port.sv
`timescale 1ns/1ps
module pal_host_port
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W   = PAL_IDX_W,
  parameter int unsigned ENTRY_W = PAL_ENTRY_W,
  parameter int unsigned COLOR_W = PAL_COLOR_W,
  parameter int unsigned BUS_W   = PAL_BUS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idx_load,
  input  logic [IDX_W-1:0]   idx_wdata,
  input  logic               data_wr,
  input  logic               data_rd,
  input  logic [BUS_W-1:0]   data_wdata,
  input  logic               sig_rd_en,
  input  logic [COLOR_W-1:0] sig_value,
  input  logic [ENTRY_W-1:0] pix_index,
  output logic [IDX_W-1:0]   pal_index,
  output logic               rd_valid,
  output logic [BUS_W-1:0]   rd_data,
  output logic [COLOR_W-1:0] pix_color
);

  localparam int unsigned RSVD_W = BUS_W - COLOR_W;

  host_op_e           op;
  logic               op_write;
  logic               op_pal_rd;
  logic               op_sig_rd;
  logic               host_slot;
  logic [IDX_W-1:0]   idx;
  logic [ENTRY_W-1:0] ram_addr;
  logic [COLOR_W-1:0] ram_q;
  logic [RSVD_W-1:0]  rsvd_q;

  // Arbitration: writes beat reads, and nothing is taken during reset.
  always_comb begin
    op = HOP_IDLE;
    if (!rst) begin
      if (data_wr) begin
        op = HOP_WRITE;
      end else if (data_rd) begin
        op = sig_rd_en ? HOP_SIG_READ : HOP_PAL_READ;
      end
    end
  end

  assign op_write  = (op == HOP_WRITE);
  assign op_pal_rd = (op == HOP_PAL_READ);
  assign op_sig_rd = (op == HOP_SIG_READ);
  assign host_slot = op_write || op_pal_rd;
  assign ram_addr  = host_slot ? idx[ENTRY_W-1:0] : pix_index;

  pal_index_reg #(
    .IDX_W (IDX_W)
  ) u_index (
    .clk      (clk),
    .rst      (rst),
    .load     (idx_load),
    .load_val (idx_wdata),
    .advance  (host_slot),
    .idx      (idx)
  );

  pal_ram #(
    .AW (ENTRY_W),
    .DW (COLOR_W)
  ) u_ram (
    .clk   (clk),
    .we    (op_write),
    .addr  (ram_addr),
    .wdata (data_wdata[COLOR_W-1:0]),
    .rdata (ram_q)
  );

  // Upper data-register bits are plain storage that reads reflect.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsvd_q <= '0;
    end else if (op_write) begin
      rsvd_q <= data_wdata[BUS_W-1:COLOR_W];
    end
  end

  pal_pixel_hold #(
    .DW (COLOR_W)
  ) u_pixel (
    .clk       (clk),
    .rst       (rst),
    .host_slot (host_slot),
    .ram_q     (ram_q),
    .pix_color (pix_color)
  );

  pal_host_read #(
    .DW    (COLOR_W),
    .BUS_W (BUS_W)
  ) u_read (
    .clk       (clk),
    .rst       (rst),
    .rd_pal    (op_pal_rd),
    .rd_sig    (op_sig_rd),
    .sig_value (sig_value),
    .ram_q     (ram_q),
    .rsvd_byte (rsvd_q),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign pal_index = idx;

  // R8: a signature read leaves the index where it was
  a_r8_sig_keeps_index: assert property (@(posedge clk) disable iff (rst)
    (op_sig_rd && !idx_load) |=> pal_index == $past(pal_index));

endmodule

// File: tb/pal_host_port_tb.sv
`timescale 1ns/1ps
module pal_host_port_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_load = 1'b0;
  logic [8:0]  idx_wdata = '0;
  logic        data_wr = 1'b0;
  logic        data_rd = 1'b0;
  logic [31:0] data_wdata = '0;
  logic        sig_rd_en = 1'b0;
  logic [23:0] sig_value = '0;
  logic [7:0]  pix_index = '0;
  logic [8:0]  pal_index;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [23:0] pix_color;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_rsvd = 8'h00;

  always #2 clk = ~clk;

  pal_host_port u_dut (
    .clk(clk), .rst(rst), .idx_load(idx_load), .idx_wdata(idx_wdata),
    .data_wr(data_wr), .data_rd(data_rd), .data_wdata(data_wdata),
    .sig_rd_en(sig_rd_en), .sig_value(sig_value), .pix_index(pix_index),
    .pal_index(pal_index), .rd_valid(rd_valid), .rd_data(rd_data),
    .pix_color(pix_color)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_idx(input logic [8:0] v);
    @(negedge clk); idx_load = 1'b1; idx_wdata = v;
    @(negedge clk); idx_load = 1'b0;
  endtask

  task automatic host_write(input logic [31:0] d);
    @(negedge clk); data_wr = 1'b1; data_wdata = d;
    @(negedge clk); data_wr = 1'b0;
    exp_rsvd = d[31:24];
  endtask

  task automatic host_read(output logic [31:0] d, output logic v);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    @(negedge clk); d = rd_data; v = rd_valid;
  endtask

  task automatic pixel_color(input logic [7:0] p, output logic [23:0] c);
    @(negedge clk); pix_index = p;
    @(negedge clk);
    @(negedge clk); c = pix_color;
  endtask

  task automatic t_reset();
    check("R1 index after reset", 32'(pal_index), 32'h0);
    check("R1 rd_valid after reset", 32'(rd_valid), 32'h0);
    check("R1 pix_color after reset", 32'(pix_color), 32'h0);
  endtask

  task automatic t_load();
    load_idx(9'h1A5);
    check("R2 index load keeps bit 8", 32'(pal_index), 32'h1A5);
  endtask

  task automatic t_burst();
    logic [31:0] d; logic v; logic [23:0] c;
    load_idx(9'h010);
    for (int i = 0; i < 4; i++) host_write({8'h5C, 16'hAA00, 8'(i)});
    check("R4 index after write burst", 32'(pal_index), 32'h014);
    load_idx(9'h010);
    for (int i = 0; i < 4; i++) begin
      host_read(d, v);
      check("R5 read valid", 32'(v), 32'h1);
      check("R3 read data with reserved byte", d, {8'h5C, 16'hAA00, 8'(i)});
    end
    check("R4 index after read burst", 32'(pal_index), 32'h014);
    pixel_color(8'h12, c);
    check("R6 pixel lookup entry 12", 32'(c), 32'h00AA0002);
    pixel_color(8'h11, c);
    check("R6 pixel lookup entry 11", 32'(c), 32'h00AA0001);
  endtask

  task automatic t_pipelined_reads();
    load_idx(9'h010);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 back-to-back first", rd_data, {exp_rsvd, 24'hAA0000});
    @(negedge clk); data_rd = 1'b0;
    check("R5 back-to-back second", rd_data, {exp_rsvd, 24'hAA0001});
    @(negedge clk);
    check("R5 back-to-back third", rd_data, {exp_rsvd, 24'hAA0002});
    @(negedge clk);
    check("R5 no valid after stream", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_hold();
    logic [23:0] c;
    pixel_color(8'h10, c);
    check("R6 steady color A", 32'(c), 32'h00AA0000);
    load_idx(9'h040);
    @(negedge clk); pix_index = 8'h13; data_wr = 1'b1; data_wdata = 32'h5C123123;
    @(negedge clk); data_wr = 1'b0;
    exp_rsvd = 8'h5C;
    @(negedge clk);
    check("R7 output held through host slot", 32'(pix_color), 32'h00AA0000);
    @(negedge clk);
    check("R7 output resumes after hold", 32'(pix_color), 32'h00AA0003);
  endtask

  task automatic t_signature();
    logic [31:0] d; logic v; logic [23:0] c;
    pixel_color(8'h10, c);
    load_idx(9'h030);
    sig_rd_en = 1'b1; sig_value = 24'h123456;
    @(negedge clk); data_rd = 1'b1; pix_index = 8'h11;
    @(negedge clk); data_rd = 1'b0; sig_value = 24'h0F0F0F;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    check("R8 signature read valid", 32'(v), 32'h1);
    check("R8 signature read data", d, {exp_rsvd, 24'h123456});
    check("R8 no pixel hold on signature read", 32'(pix_color), 32'h00AA0001);
    check("R8 index unchanged", 32'(pal_index), 32'h030);
    host_write(32'h21777777);
    check("R10 write in signature mode advances", 32'(pal_index), 32'h031);
    sig_rd_en = 1'b0;
    load_idx(9'h030);
    host_read(d, v);
    check("R10 write in signature mode stored", d, 32'h21777777);
  endtask

  task automatic t_wrap();
    logic [23:0] c;
    load_idx(9'h1FF);
    host_write(32'h00BEEF01);
    check("R4 index wraps 511 to 0", 32'(pal_index), 32'h000);
    pixel_color(8'hFF, c);
    check("R4 index 511 reaches entry 255", 32'(c), 32'h00BEEF01);
    load_idx(9'h100);
    host_write(32'h00C0FFEE);
    check("R4 index after 256", 32'(pal_index), 32'h101);
    pixel_color(8'h00, c);
    check("R4 index 256 aliases entry 0", 32'(c), 32'h00C0FFEE);
  endtask

  task automatic t_priority();
    logic [23:0] c;
    load_idx(9'h050);
    @(negedge clk); data_wr = 1'b1; data_rd = 1'b1; data_wdata = 32'h33ABCDEF;
    @(negedge clk); data_wr = 1'b0; data_rd = 1'b0;
    exp_rsvd = 8'h33;
    check("R9 single increment on collision", 32'(pal_index), 32'h051);
    @(negedge clk);
    check("R9 no read return on collision", 32'(rd_valid), 32'h0);
    pixel_color(8'h50, c);
    check("R9 write performed on collision", 32'(c), 32'h00ABCDEF);
    @(negedge clk); idx_load = 1'b1; idx_wdata = 9'h060; data_wr = 1'b1; data_wdata = 32'h33135790;
    @(negedge clk); idx_load = 1'b0; data_wr = 1'b0;
    check("R9 load wins over increment", 32'(pal_index), 32'h060);
    pixel_color(8'h51, c);
    check("R9 access used old index", 32'(c), 32'h00135790);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_burst();
    t_pipelined_reads();
    t_hold();
    t_signature();
    t_wrap();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule